// File: doc/BRIEF.md
# Coprocessor Mailbox Store

This block is a shared 512-word by 16-bit store that sits between a host processor and an external coprocessor. The host reaches it through a simple synchronous request/ready port with per-byte write strobes. The coprocessor reaches it through a pin-level port that behaves like an asynchronous static RAM: a 9-bit word address, an active-low select, an active-low output enable, a read-not-write line and one active-low enable per byte lane. Data in and data out are separate buses, and the out bus carries a per-lane drive enable for the pad.

Ownership of the store passes through a request/grant handshake. The coprocessor raises its request. The block answers with a grant. While the grant stands, the host is stalled and only the coprocessor can use the store. Coprocessor pins are resynchronised before they are used. A coprocessor write is captured while it is active and is committed to the store in the cycle after it ends. It ends when the select, the direction or the byte enables are released, whichever happens first, or when the grant is withdrawn.

Top module: `cpmbx_top`

## Requirements
- R1: The store holds 512 words of 16 bits. A host write (h_we_i=1, h_be_i=2'b11) to any address, 0 and 511 included, is returned by a later host read of that address on h_rdata_o one clock after the read is accepted (h_ready_o=1 at that edge).
- R2: While granted, a coprocessor write with ext_ncs_i=0, ext_rnw_i=0 and both ext_nbe_i bits low stores ext_d_i at word ext_addr_i. The host reads it back after the grant is released.
- R3: A byte lane whose enable is off leaves that byte of the addressed word unchanged. On the host side h_be_i is active high. On the coprocessor side ext_nbe_i is active low. Bit 1 is the upper byte [15:8] and bit 0 is the lower byte [7:0] on both sides.
- R4: A coprocessor write is committed when it ends. It may end by raising ext_ncs_i, by raising ext_rnw_i, or by raising both ext_nbe_i bits. The store takes the lanes, address and data held in the last cycle before the end.
- R5: ext_d_oe_o[l] is high only while the grant is held, ext_ncs_i=0, ext_noe_i=0, ext_rnw_i=1 and ext_nbe_i[l]=0. Otherwise it is low. When lanes are enabled, ext_d_o carries the word at ext_addr_i once the address has been held for 4 clocks.
- R6: ext_gnt_o rises at the second rising edge after the first edge that samples ext_req_i high. It is never at the first such edge.
- R7: ext_gnt_o falls at the second rising edge after the first edge that samples ext_req_i low.
- R8: While ext_gnt_o is high, h_ready_o stays low and no host access is performed.
- R9: Coprocessor writes made without a grant leave the store unchanged, and ext_d_oe_o stays 2'b00.
- R10: During and right after reset, ext_gnt_o=0 and ext_d_oe_o=2'b00, even when the coprocessor pins request a read.
- R11: When a coprocessor write commit falls in the first cycle after the grant drops, the commit takes the store's write port and h_ready_o stays low for that cycle. The host access is taken in the next cycle and sees the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| h_req_i | input | 1 | Host access request |
| h_we_i | input | 1 | Host write (1) or read (0) |
| h_be_i | input | 2 | Host byte strobes, active high, bit 1 is the upper byte |
| h_addr_i | input | 9 | Host word address |
| h_wdata_i | input | 16 | Host write data |
| h_ready_o | output | 1 | Host access taken at this edge |
| h_rdata_o | output | 16 | Host read data, valid the cycle after acceptance |
| ext_req_i | input | 1 | Coprocessor ownership request |
| ext_gnt_o | output | 1 | Coprocessor ownership grant |
| ext_addr_i | input | 9 | Coprocessor word address |
| ext_ncs_i | input | 1 | Coprocessor select, active low |
| ext_noe_i | input | 1 | Coprocessor output enable, active low |
| ext_rnw_i | input | 1 | Coprocessor direction, 1 = read |
| ext_nbe_i | input | 2 | Coprocessor byte enables, active low, bit 1 is the upper byte |
| ext_d_i | input | 16 | Coprocessor write data |
| ext_d_o | output | 16 | Coprocessor read data |
| ext_d_oe_o | output | 2 | Per-lane drive enable for ext_d_o |

## Verification
Two functions can land in the same cycle: the commit of a coprocessor write and a waiting host access that the falling grant has just released. The bench provokes this by letting go of the select and the request on the same clock while a host read of the same word is already pending. It then samples h_ready_o in each of the following cycles. The bench requires ready to stay low both in the last granted cycle and in the commit cycle, to rise one cycle later, and the read data to equal the word the coprocessor wrote.

// File: rtl/cpmbx_pkg.sv
package cpmbx_pkg;

   // ownership of the shared store
   typedef enum logic [0:0] {
      ARB_HOST = 1'b0,
      ARB_EXT  = 1'b1
   } arb_state_e;

   // number of byte lanes in a word
   function automatic int lane_count(input int data_width);
      return data_width / 8;
   endfunction

endpackage

// File: rtl/cpmbx_sync.sv
module cpmbx_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("cpmbx_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain[0] <= RST_VAL;
               else         chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain[s] <= RST_VAL;
               else         chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/cpmbx_arb.sv
module cpmbx_arb
   import cpmbx_pkg::*;
#(
   parameter int REQ_STAGES = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic gnt_o
);

   logic       req_s;
   arb_state_e state_q, state_d;
   logic [1:0] age_q;

   // request crosses in through the synchronizer; the state flop is the final stage
   cpmbx_sync #(
      .WIDTH  (1),
      .STAGES (REQ_STAGES),
      .RST_VAL(1'b0)
   ) u_req_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (req_i),
      .q_o   (req_s)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_HOST: if (req_s)  state_d = ARB_EXT;
         ARB_EXT:  if (!req_s) state_d = ARB_HOST;
         default:  state_d = ARB_HOST;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ARB_HOST;
      else         state_q <= state_d;
   end

   assign gnt_o = (state_q == ARB_EXT);

   // cycles since reset, saturating, so the history checks stay inside them
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   // R6
   gnt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd3 && $rose(gnt_o)) |-> $past(req_i, 2));

   // R7
   gnt_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd3 && $fell(gnt_o)) |-> !$past(req_i, 2));

endmodule

// File: rtl/cpmbx_store.sv
module cpmbx_store #(
   parameter int DEPTH = 512,
   parameter int AW    = 9,
   parameter int DW    = 16
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   // port A: coprocessor commit, takes priority
   input  logic            a_en_i,
   input  logic [AW-1:0]   a_addr_i,
   input  logic [DW-1:0]   a_data_i,
   input  logic [DW/8-1:0] a_lane_i,
   // port B: host write
   input  logic            b_en_i,
   input  logic [AW-1:0]   b_addr_i,
   input  logic [DW-1:0]   b_data_i,
   input  logic [DW/8-1:0] b_lane_i,
   // host read
   input  logic            hr_en_i,
   input  logic [AW-1:0]   hr_addr_i,
   output logic [DW-1:0]   hr_data_o,
   // coprocessor read, refreshed every cycle
   input  logic [AW-1:0]   xr_addr_i,
   output logic [DW-1:0]   xr_data_o
);

   localparam int LANES = DW / 8;

   generate
      if (DEPTH > (1 << AW)) begin : g_bad_depth
         $error("cpmbx_store: DEPTH does not fit in AW address bits");
      end
      if (DW % 8 != 0) begin : g_bad_dw
         $error("cpmbx_store: DW must be a whole number of bytes");
      end
   endgenerate

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [7:0] bank [DEPTH];
         logic [7:0] hr_q;
         logic [7:0] xr_q;

         always_ff @(posedge clk_i) begin
            if (a_en_i && a_lane_i[l])
               bank[a_addr_i] <= a_data_i[8*l +: 8];
            else if (b_en_i && b_lane_i[l])
               bank[b_addr_i] <= b_data_i[8*l +: 8];
         end

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               hr_q <= '0;
               xr_q <= '0;
            end else begin
               if (hr_en_i) hr_q <= bank[hr_addr_i];
               xr_q <= bank[xr_addr_i];
            end
         end

         assign hr_data_o[8*l +: 8] = hr_q;
         assign xr_data_o[8*l +: 8] = xr_q;
      end
   endgenerate

   // R11
   one_writer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({a_en_i, b_en_i}));

endmodule

// File: rtl/cpmbx_top.sv
module cpmbx_top
   import cpmbx_pkg::*;
#(
   parameter int AW         = 9,
   parameter int DEPTH      = 512,
   parameter int DW         = 16,
   parameter int BUS_STAGES = 2,
   parameter int REQ_STAGES = 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            h_req_i,
   input  logic            h_we_i,
   input  logic [DW/8-1:0] h_be_i,
   input  logic [AW-1:0]   h_addr_i,
   input  logic [DW-1:0]   h_wdata_i,
   output logic            h_ready_o,
   output logic [DW-1:0]   h_rdata_o,
   input  logic            ext_req_i,
   output logic            ext_gnt_o,
   input  logic [AW-1:0]   ext_addr_i,
   input  logic            ext_ncs_i,
   input  logic            ext_noe_i,
   input  logic            ext_rnw_i,
   input  logic [DW/8-1:0] ext_nbe_i,
   input  logic [DW-1:0]   ext_d_i,
   output logic [DW-1:0]   ext_d_o,
   output logic [DW/8-1:0] ext_d_oe_o
);

   localparam int LANES = lane_count(DW);
   localparam int BW    = 2 + LANES + AW + DW;
   localparam logic [BW-1:0] BUS_IDLE = {2'b11, {LANES{1'b1}}, {(AW + DW){1'b0}}};

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("cpmbx_top: DW must hold at least one byte");
      end
      if (BUS_STAGES < 2) begin : g_bad_bus_sync
         $error("cpmbx_top: BUS_STAGES must be at least 2");
      end
   endgenerate

   // ---------------- arbitration ----------------
   logic gnt;

   cpmbx_arb #(
      .REQ_STAGES(REQ_STAGES)
   ) u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (ext_req_i),
      .gnt_o (gnt)
   );

   assign ext_gnt_o = gnt;

   // ---------------- coprocessor pin capture ----------------
   logic [BW-1:0]    bus_s;
   logic             s_ncs, s_rnw;
   logic [LANES-1:0] s_nbe;
   logic [AW-1:0]    s_addr;
   logic [DW-1:0]    s_d;

   cpmbx_sync #(
      .WIDTH  (BW),
      .STAGES (BUS_STAGES),
      .RST_VAL(BUS_IDLE)
   ) u_bus_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({ext_ncs_i, ext_rnw_i, ext_nbe_i, ext_addr_i, ext_d_i}),
      .q_o   (bus_s)
   );

   assign {s_ncs, s_rnw, s_nbe, s_addr, s_d} = bus_s;

   // write in progress: selected, writing, some lane on, and owned
   logic             wr_act, wr_act_q, commit;
   logic [AW-1:0]    cap_addr;
   logic [DW-1:0]    cap_data;
   logic [LANES-1:0] cap_lane;

   assign wr_act = gnt && !s_ncs && !s_rnw && (s_nbe != {LANES{1'b1}});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_act_q <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
         cap_lane <= '0;
      end else begin
         wr_act_q <= wr_act;
         if (wr_act) begin
            cap_addr <= s_addr;
            cap_data <= s_d;
            cap_lane <= ~s_nbe;
         end
      end
   end

   // the first cycle after the write ends, by any of its strobes
   assign commit = wr_act_q && !wr_act;

   // ---------------- host port ----------------
   assign h_ready_o = h_req_i && !gnt && !commit;

   // ---------------- store ----------------
   logic [DW-1:0] xr_data;

   cpmbx_store #(
      .DEPTH(DEPTH),
      .AW   (AW),
      .DW   (DW)
   ) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .a_en_i   (commit),
      .a_addr_i (cap_addr),
      .a_data_i (cap_data),
      .a_lane_i (cap_lane),
      .b_en_i   (h_ready_o && h_we_i),
      .b_addr_i (h_addr_i),
      .b_data_i (h_wdata_i),
      .b_lane_i (h_be_i),
      .hr_en_i  (h_ready_o && !h_we_i),
      .hr_addr_i(h_addr_i),
      .hr_data_o(h_rdata_o),
      .xr_addr_i(s_addr),
      .xr_data_o(xr_data)
   );

   assign ext_d_o = xr_data;

   // ---------------- per-lane pad drive ----------------
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_oe
         assign ext_d_oe_o[l] = gnt && !ext_ncs_i && !ext_noe_i && ext_rnw_i && !ext_nbe_i[l];
      end
   endgenerate

   // R8
   host_lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt |-> !h_ready_o);

   // R4
   commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit |=> !commit);

   // R5
   drive_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_d_oe_o != '0) |-> (ext_rnw_i && gnt));

endmodule

// File: tb/cpmbx_top_tb.sv
module cpmbx_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_req = 1'b0, h_we = 1'b0;
   logic [1:0]  h_be = 2'b00;
   logic [8:0]  h_addr = '0;
   logic [15:0] h_wdata = '0;
   logic        h_ready;
   logic [15:0] h_rdata;
   logic        ext_req = 1'b0, ext_gnt;
   logic [8:0]  ext_addr = '0;
   logic        ext_ncs = 1'b1, ext_noe = 1'b1, ext_rnw = 1'b1;
   logic [1:0]  ext_nbe = 2'b11;
   logic [15:0] ext_din = '0;
   logic [15:0] ext_dout;
   logic [1:0]  ext_oe;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   cpmbx_top u_dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .h_req_i   (h_req),
      .h_we_i    (h_we),
      .h_be_i    (h_be),
      .h_addr_i  (h_addr),
      .h_wdata_i (h_wdata),
      .h_ready_o (h_ready),
      .h_rdata_o (h_rdata),
      .ext_req_i (ext_req),
      .ext_gnt_o (ext_gnt),
      .ext_addr_i(ext_addr),
      .ext_ncs_i (ext_ncs),
      .ext_noe_i (ext_noe),
      .ext_rnw_i (ext_rnw),
      .ext_nbe_i (ext_nbe),
      .ext_d_i   (ext_din),
      .ext_d_o   (ext_dout),
      .ext_d_oe_o(ext_oe)
   );

   // {we, be[1:0], addr[8:0], wdata[15:0], expected read[15:0]}
   localparam logic [43:0] VEC [8] = '{
      {1'b1, 2'b11, 9'd0,   16'hA5C3, 16'h0000},
      {1'b1, 2'b11, 9'd511, 16'h5A3C, 16'h0000},
      {1'b0, 2'b00, 9'd0,   16'h0000, 16'hA5C3},
      {1'b0, 2'b00, 9'd511, 16'h0000, 16'h5A3C},
      {1'b1, 2'b01, 9'd0,   16'hFF11, 16'h0000},
      {1'b0, 2'b00, 9'd0,   16'h0000, 16'hA511},
      {1'b1, 2'b10, 9'd511, 16'h77EE, 16'h0000},
      {1'b0, 2'b00, 9'd511, 16'h0000, 16'h773C}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic host_op(input logic we, input logic [1:0] be, input logic [8:0] addr,
                          input logic [15:0] wdata, input logic [15:0] exp, input string tag);
      @(negedge clk);
      h_req = 1'b1; h_we = we; h_be = be; h_addr = addr; h_wdata = wdata;
      #1;
      while (!h_ready) @(negedge clk);
      @(negedge clk);
      h_req = 1'b0; h_we = 1'b0;
      if (!we) chk(tag, h_rdata, exp);
   endtask

   // mode 0: select released, 1: direction released, 2: byte enables released
   task automatic ext_write(input logic [8:0] addr, input logic [15:0] data,
                            input logic [1:0] nbe, input int mode);
      @(negedge clk);
      ext_addr = addr; ext_din = data; ext_nbe = nbe;
      ext_rnw = 1'b0; ext_noe = 1'b1; ext_ncs = 1'b0;
      repeat (3) @(negedge clk);
      case (mode)
         0:       ext_ncs = 1'b1;
         1:       ext_rnw = 1'b1;
         default: ext_nbe = 2'b11;
      endcase
      repeat (2) @(negedge clk);
      ext_ncs = 1'b1; ext_rnw = 1'b1; ext_nbe = 2'b11;
      repeat (5) @(negedge clk);
   endtask

   task automatic ext_read(input logic [8:0] addr, input logic [1:0] nbe, input logic noe,
                           input logic ncs, input logic [1:0] exp_oe,
                           input logic [15:0] exp_d, input string tag);
      @(negedge clk);
      ext_addr = addr; ext_rnw = 1'b1; ext_nbe = nbe; ext_noe = noe; ext_ncs = ncs;
      repeat (4) @(negedge clk);
      chk(tag, ext_oe, exp_oe);
      if (exp_oe != 2'b00) chk(tag, ext_dout, exp_d);
      ext_ncs = 1'b1; ext_noe = 1'b1; ext_nbe = 2'b11;
   endtask

   initial begin
      // R10: read-like pins asserted while in reset
      ext_ncs = 1'b0; ext_noe = 1'b0; ext_rnw = 1'b1; ext_nbe = 2'b00; ext_req = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 grant in reset", ext_gnt, 1'b0);
      chk("R10 drive in reset", ext_oe, 2'b00);
      ext_req = 1'b0; ext_ncs = 1'b1; ext_noe = 1'b1; ext_nbe = 2'b11;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 grant after reset", ext_gnt, 1'b0);
      chk("R10 drive after reset", ext_oe, 2'b00);

      // vector walk: R1 for entries 0..3, R3 for entries 4..7
      for (int i = 0; i < 8; i++) begin
         host_op(VEC[i][43], VEC[i][42:41], VEC[i][40:32], VEC[i][31:16], VEC[i][15:0],
                 (i < 4) ? "R1 host word" : "R3 host lane");
      end

      // R6: grant not at the first edge after request, yes at the second
      @(negedge clk);
      ext_req = 1'b1;
      @(negedge clk);
      chk("R6 grant too early", ext_gnt, 1'b0);
      @(negedge clk);
      chk("R6 grant on time", ext_gnt, 1'b1);

      // R8: host held off while granted
      h_req = 1'b1; h_we = 1'b0; h_addr = 9'd0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R8 host stalled", h_ready, 1'b0);
      end
      h_req = 1'b0;

      // R2/R4: writes ended by select, direction and byte enables
      ext_write(9'd5, 16'h1234, 2'b00, 0);
      ext_write(9'd6, 16'hBEEF, 2'b00, 1);
      ext_write(9'd7, 16'h0F0F, 2'b00, 2);
      // R3: upper lane only (nbe bit 1 low), lower byte of word 0 keeps 8'h11
      ext_write(9'd0, 16'h9900, 2'b01, 0);

      // R5: per-lane drive
      ext_read(9'd5, 2'b00, 1'b0, 1'b0, 2'b11, 16'h1234, "R5 both lanes");
      ext_read(9'd6, 2'b10, 1'b0, 1'b0, 2'b01, 16'hBEEF, "R5 lower lane");
      ext_read(9'd6, 2'b00, 1'b1, 1'b0, 2'b00, 16'h0000, "R5 oe off");
      ext_read(9'd6, 2'b00, 1'b0, 1'b1, 2'b00, 16'h0000, "R5 select off");

      // R7: grant drops at the second edge
      @(negedge clk);
      ext_req = 1'b0;
      @(negedge clk);
      chk("R7 grant held one edge", ext_gnt, 1'b1);
      @(negedge clk);
      chk("R7 grant dropped", ext_gnt, 1'b0);

      host_op(1'b0, 2'b00, 9'd5, 16'h0, 16'h1234, "R2 ended by select");
      host_op(1'b0, 2'b00, 9'd6, 16'h0, 16'hBEEF, "R4 ended by direction");
      host_op(1'b0, 2'b00, 9'd7, 16'h0, 16'h0F0F, "R4 ended by lanes");
      host_op(1'b0, 2'b00, 9'd0, 16'h0, 16'h9911, "R3 coprocessor lane");

      // R9: no grant, no write and no drive
      ext_write(9'd5, 16'h0000, 2'b00, 0);
      host_op(1'b0, 2'b00, 9'd5, 16'h0, 16'h1234, "R9 ungranted write");
      ext_read(9'd5, 2'b00, 1'b0, 1'b0, 2'b00, 16'h0000, "R9 ungranted drive");

      // R11: commit and released host access in the same cycle
      @(negedge clk);
      ext_req = 1'b1;
      repeat (3) @(negedge clk);
      ext_addr = 9'd8; ext_din = 16'hCAFE; ext_nbe = 2'b00;
      ext_rnw = 1'b0; ext_noe = 1'b1; ext_ncs = 1'b0;
      repeat (3) @(negedge clk);
      ext_ncs = 1'b1; ext_req = 1'b0;
      h_req = 1'b1; h_we = 1'b0; h_addr = 9'd8;
      @(negedge clk);
      chk("R11 last granted cycle", h_ready, 1'b0);
      @(negedge clk);
      chk("R11 commit cycle stalls host", h_ready, 1'b0);
      @(negedge clk);
      chk("R11 host taken after commit", h_ready, 1'b1);
      @(negedge clk);
      chk("R11 host sees commit", h_rdata, 16'hCAFE);
      h_req = 1'b0;
      ext_rnw = 1'b1; ext_nbe = 2'b11;
      repeat (2) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule